// File: doc/BRIEF.md
# Burst DMA Output Sequencer

This block moves a block of bytes from memory to an output device in fixed-size bursts. A single start word holds a negative byte count and a start address. The block latches both and runs the first burst at once. It fetches memory words one at a time through a request/acknowledge port, and a byte unpacker downstream splits each word into bytes. At the start of each burst the block tells the unpacker how many bytes that burst holds.

The burst size depends on the packing mode:

| Mode | Packing | Burst size |
|------|---------|------------|
| 1 (mode 0 behaves the same) | five 7-bit bytes per word | 60 bytes |
| 2 | four 8-bit bytes per word | 64 bytes |
| 3 | nine 8-bit bytes per two words | 63 bytes |

After a burst, the block keeps the next address and the remaining count, raises its interrupt enable and waits for a device request. A request with bytes still left starts the next burst. A request with nothing left ends the transfer: busy clears and done sets.

The sequencer has four states:
- IDLE: on start, go to SETUP.
- SETUP: size the burst and deduct it from the count, then go to FETCH.
- FETCH: on the acknowledge of the last word of the burst, go to WAIT.
- WAIT: on a device request, go to SETUP while bytes remain, otherwise go to IDLE and set done.

Top module: `dma_burst_seq`

## Requirements
- R1: After reset, busy, done, reject, irq_en, fetch_req and burst_start are all 0.
- R2: In IDLE, start_valid loads the count from start_word[2W-1:W] and the address from start_word[W-1:0]. It sets busy and clears done on the next edge, and burst_start rises one cycle after that.
- R3: A count field of zero means 2^W bytes: 262144 with the default W=18.
- R4: burst_bytes during burst_start is 60 for mode 1 or mode 0, 64 for mode 2 and 63 for mode 3. The mode is sampled at start.
- R5: When fewer bytes remain than the burst size, the burst is cut to the remaining bytes and the saved remainder becomes zero.
- R6: A burst of b bytes fetches exactly ceil(b/5) words in modes 0 and 1, ceil(b/4) in mode 2 and ceil(2b/9) in mode 3. The last acknowledged word moves the block to WAIT.
- R7: Fetch addresses start at the start address and step by one on each acknowledged word, wrapping modulo 2^W. While fetch_ack is low, fetch_req and fetch_addr hold.
- R8: Between bursts, irq_en is high and fetch_req is low. The next burst resumes at the saved address with the saved remainder.
- R9: A dev_req in WAIT with zero remaining clears busy, sets done and drops irq_en on the next edge.
- R10: A start_valid while busy pulses reject for one cycle on the next edge and changes neither busy, the address nor the count.
- R11: dbg_word holds the two's-complement negation of the remaining count (mod 2^W) in its upper half and the next fetch address in its lower half.
- R12: A dev_req outside WAIT has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start word strobe |
| start_word | input | 2*HALF_W | Negative count (upper half), start address (lower half) |
| mode | input | 2 | Packing mode |
| dev_req | input | 1 | Device request for the next burst |
| fetch_ack | input | 1 | Memory word delivered |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished |
| reject | output | 1 | One-cycle pulse: start refused while busy |
| irq_en | output | 1 | Device interrupt enabled, waiting for request |
| fetch_req | output | 1 | Word fetch request |
| fetch_addr | output | HALF_W | Word address |
| burst_start | output | 1 | One-cycle pulse at burst begin |
| burst_bytes | output | BLEN_W | Bytes in current burst |
| dbg_word | output | 2*HALF_W | Negated remaining count and current address |

## Verification
The bench builds the block with HALF_W=8 and keeps the three default burst sizes. A zero count then means only 256 bytes, so a full-size transfer of five bursts runs in a few hundred cycles, and the address wrap past 255 is reached from start addresses near the top. This allows a sweep of all four mode codes against counts of 1, 59, 60, 61, 63, 64, 65, 130 and 256 bytes, which covers exact, short and single-byte final bursts. The fetch acknowledges include stalls that carry a stray device request.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_FETCH = 2'd2,
        ST_WAIT  = 2'd3
    } seq_state_t;

    localparam logic [1:0] MODE_SEVEN = 2'd1;
    localparam logic [1:0] MODE_EIGHT = 2'd2;
    localparam logic [1:0] MODE_NINE  = 2'd3;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dma_burst_sizer.sv
module dma_burst_sizer
    import dma_seq_pkg::*;
#(
    parameter int REM_W    = 19,
    parameter int BLEN_W   = 7,
    parameter int BURST_M1 = 60,
    parameter int BURST_M2 = 64,
    parameter int BURST_M3 = 63
) (
    input  logic [1:0]        mode,
    input  logic [REM_W-1:0]  remaining,
    output logic [BLEN_W-1:0] blen
);

    logic [BLEN_W-1:0] full_size;

    always_comb begin
        unique case (mode)
            MODE_EIGHT: full_size = BLEN_W'(BURST_M2);
            MODE_NINE:  full_size = BLEN_W'(BURST_M3);
            default:    full_size = BLEN_W'(BURST_M1);
        endcase
    end

    always_comb begin
        if (remaining < REM_W'(full_size))
            blen = remaining[BLEN_W-1:0];
        else
            blen = full_size;
    end

endmodule

// File: rtl/dma_word_pacer.sv
module dma_word_pacer
    import dma_seq_pkg::*;
#(
    parameter int BLEN_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [1:0]        mode,
    input  logic [BLEN_W-1:0] burst_len,
    output logic              last_word
);

    localparam int ACC_W = BLEN_W + 1;

    logic [ACC_W-1:0] acc_q;
    logic             odd_q;
    logic [ACC_W-1:0] credit;

    always_comb begin
        unique case (mode)
            MODE_EIGHT: credit = ACC_W'(4);
            MODE_NINE:  credit = odd_q ? ACC_W'(5) : ACC_W'(4);
            default:    credit = ACC_W'(5);
        endcase
    end

    assign last_word = (acc_q + credit) >= {1'b0, burst_len};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            odd_q <= 1'b0;
        end else if (clear) begin
            acc_q <= '0;
            odd_q <= 1'b0;
        end else if (step) begin
            acc_q <= acc_q + credit;
            odd_q <= ~odd_q;
        end
    end

endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
    import dma_seq_pkg::*;
#(
    parameter int HALF_W   = 18,
    parameter int BURST_M1 = 60,
    parameter int BURST_M2 = 64,
    parameter int BURST_M3 = 63,
    parameter int BLEN_W   = $clog2(max3(BURST_M1, BURST_M2, BURST_M3) + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_valid,
    input  logic [2*HALF_W-1:0]   start_word,
    input  logic [1:0]            mode,
    input  logic                  dev_req,
    input  logic                  fetch_ack,
    output logic                  busy,
    output logic                  done,
    output logic                  reject,
    output logic                  irq_en,
    output logic                  fetch_req,
    output logic [HALF_W-1:0]     fetch_addr,
    output logic                  burst_start,
    output logic [BLEN_W-1:0]     burst_bytes,
    output logic [2*HALF_W-1:0]   dbg_word
);

    localparam int REM_W  = HALF_W + 1;
    localparam int WORD_W = 2 * HALF_W;
    localparam logic [REM_W-1:0] FULL_COUNT = {1'b1, {HALF_W{1'b0}}};

    seq_state_t         state_q, state_d;
    logic [HALF_W-1:0]  addr_q;
    logic [REM_W-1:0]   rem_q;
    logic [1:0]         mode_q;
    logic [BLEN_W-1:0]  blen_q;
    logic               busy_q, done_q, reject_q, bstart_q;
    logic [BLEN_W-1:0]  next_blen;
    logic               last_word;
    logic [HALF_W-1:0]  start_cnt;
    logic               accept, word_taken, finish;

    assign start_cnt  = start_word[WORD_W-1:HALF_W];
    assign accept     = (state_q == ST_IDLE) && start_valid;
    assign word_taken = (state_q == ST_FETCH) && fetch_ack;
    assign finish     = (state_q == ST_WAIT) && dev_req && (rem_q == '0);

    dma_burst_sizer #(
        .REM_W    (REM_W),
        .BLEN_W   (BLEN_W),
        .BURST_M1 (BURST_M1),
        .BURST_M2 (BURST_M2),
        .BURST_M3 (BURST_M3)
    ) u_sizer (
        .mode      (mode_q),
        .remaining (rem_q),
        .blen      (next_blen)
    );

    dma_word_pacer #(
        .BLEN_W (BLEN_W)
    ) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state_q == ST_SETUP),
        .step      (word_taken),
        .mode      (mode_q),
        .burst_len (blen_q),
        .last_word (last_word)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_valid) state_d = ST_SETUP;
            ST_SETUP: state_d = ST_FETCH;
            ST_FETCH: if (fetch_ack && last_word) state_d = ST_WAIT;
            ST_WAIT:  if (dev_req) state_d = (rem_q == '0) ? ST_IDLE : ST_SETUP;
            default:  state_d = ST_IDLE;
        endcase
    end

    // transfer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            rem_q    <= '0;
            mode_q   <= '0;
            blen_q   <= '0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            reject_q <= 1'b0;
            bstart_q <= 1'b0;
        end else begin
            reject_q <= start_valid && busy_q;
            bstart_q <= (state_q == ST_SETUP);
            if (accept) begin
                addr_q <= start_word[HALF_W-1:0];
                rem_q  <= FULL_COUNT - REM_W'(start_cnt);
                mode_q <= mode;
                busy_q <= 1'b1;
                done_q <= 1'b0;
            end
            if (state_q == ST_SETUP) begin
                blen_q <= next_blen;
                rem_q  <= rem_q - REM_W'(next_blen);
            end
            if (word_taken)
                addr_q <= addr_q + 1'b1;
            if (finish) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        fetch_req   = (state_q == ST_FETCH);
        irq_en      = (state_q == ST_WAIT);
        busy        = busy_q;
        done        = done_q;
        reject      = reject_q;
        burst_start = bstart_q;
        burst_bytes = blen_q;
        fetch_addr  = addr_q;
        dbg_word    = {HALF_W'(FULL_COUNT - rem_q), addr_q};
    end

endmodule

// File: rtl/dma_burst_seq_chk.sv
module dma_burst_seq_chk #(
    parameter int HALF_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_valid,
    input logic              dev_req,
    input logic              fetch_ack,
    input logic              busy,
    input logic              done,
    input logic              reject,
    input logic              irq_en,
    input logic              fetch_req,
    input logic [HALF_W-1:0] fetch_addr
);

    // R2
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_addr));

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && fetch_ack |=>
            (!fetch_req || fetch_addr == HALF_W'($past(fetch_addr) + 1'b1)));

    // R8
    wait_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_en && fetch_req));

    // R9
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(dev_req) && $past(irq_en));

    // R10
    reject_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid && busy |=> reject && busy);

endmodule

bind dma_burst_seq dma_burst_seq_chk #(.HALF_W(HALF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .dev_req     (dev_req),
    .fetch_ack   (fetch_ack),
    .busy        (busy),
    .done        (done),
    .reject      (reject),
    .irq_en      (irq_en),
    .fetch_req   (fetch_req),
    .fetch_addr  (fetch_addr)
);

// File: tb/test_dma_burst_seq.sv
module test_dma_burst_seq;

    localparam int W  = 8;
    localparam int BW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_valid = 1'b0;
    logic [2*W-1:0] start_word = '0;
    logic [1:0]    mode = '0;
    logic          dev_req = 1'b0;
    logic          fetch_ack = 1'b0;
    logic          busy, done, reject, irq_en, fetch_req, burst_start;
    logic [W-1:0]  fetch_addr;
    logic [BW-1:0] burst_bytes;
    logic [2*W-1:0] dbg_word;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dma_burst_seq #(.HALF_W(W)) i_dma_burst_seq (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_word(start_word),
        .mode(mode), .dev_req(dev_req), .fetch_ack(fetch_ack), .busy(busy),
        .done(done), .reject(reject), .irq_en(irq_en), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .burst_start(burst_start),
        .burst_bytes(burst_bytes), .dbg_word(dbg_word)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bsize(input int m);
        if (m == 2) return 64;
        if (m == 3) return 63;
        return 60;
    endfunction

    function automatic int nwords(input int m, input int b);
        if (m == 2) return (b + 3) / 4;
        if (m == 3) return (2 * b + 8) / 9;
        return (b + 4) / 5;
    endfunction

    task automatic xfer(input int m, input int cnt, input int a, input bit poke);
        int rem, ea, blen, nw, total;
        logic [2*W-1:0] snap;
        rem = (cnt == 0) ? 256 : 256 - cnt;
        ea = a;
        total = 0;
        @(negedge clk);
        mode = 2'(m);
        start_word = {8'(cnt), 8'(a)};
        start_valid = 1'b1;
        @(negedge clk);
        start_valid = 1'b0;
        chk(busy && !done, "R2 busy/done", {busy, done}, 2);
        while (rem > 0) begin
            blen = (rem < bsize(m)) ? rem : bsize(m);
            nw = nwords(m, blen);
            @(negedge clk);
            chk(burst_start == 1'b1, "R2 burst_start", burst_start, 1);
            if (blen < bsize(m))
                chk(burst_bytes == BW'(blen), "R5 short burst", burst_bytes, blen);
            else
                chk(burst_bytes == BW'(blen), "R4 burst size", burst_bytes, blen);
            total += blen;
            for (int w = 0; w < nw; w++) begin
                chk(fetch_req && fetch_addr == 8'(ea), "R7 address", fetch_addr, ea % 256);
                if (w % 3 == 1) begin
                    dev_req = 1'b1;
                    @(negedge clk);
                    dev_req = 1'b0;
                    chk(fetch_req && fetch_addr == 8'(ea), "R12 stall with request", fetch_addr, ea % 256);
                end
                fetch_ack = 1'b1;
                @(negedge clk);
                fetch_ack = 1'b0;
                ea = (ea + 1) % 256;
            end
            rem -= blen;
            chk(irq_en && !fetch_req, "R6 word count", {irq_en, fetch_req}, 2);
            chk(dbg_word == {8'((256 - rem) % 256), 8'(ea)}, "R11 debug word",
                dbg_word, {8'((256 - rem) % 256), 8'(ea)});
            if (poke) begin
                snap = dbg_word;
                start_word = 16'hA5A5;
                start_valid = 1'b1;
                @(negedge clk);
                start_valid = 1'b0;
                chk(reject && busy && irq_en && dbg_word == snap, "R10 reject", dbg_word, snap);
                @(negedge clk);
                chk(!reject, "R10 one-cycle pulse", reject, 0);
                poke = 1'b0;
            end
            dev_req = 1'b1;
            @(negedge clk);
            dev_req = 1'b0;
            if (rem == 0)
                chk(done && !busy && !irq_en, "R9 finish", {done, busy, irq_en}, 4);
            else
                chk(busy && !done && !irq_en && dbg_word[W-1:0] == 8'(ea), "R8 resume",
                    dbg_word[W-1:0], ea % 256);
        end
        if (cnt == 0) chk(total == 256, "R3 zero count", total, 256);
        else          chk(total == 256 - cnt, "R2 count field", total, 256 - cnt);
        dev_req = 1'b1;
        @(negedge clk);
        dev_req = 1'b0;
        @(negedge clk);
        chk(done && !busy && !fetch_req && !burst_start, "R12 idle request", {done, busy}, 2);
    endtask

    initial begin
        int cnts[9] = '{0, 255, 197, 196, 195, 193, 192, 191, 126};
        repeat (3) @(negedge clk);
        chk(!busy && !done && !reject && !irq_en && !fetch_req && !burst_start,
            "R1 reset", {busy, done, reject, irq_en, fetch_req, burst_start}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !fetch_req, "R1 after reset", {busy, done, fetch_req}, 0);
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 9; c++) begin
                xfer(m, cnts[c], 230 + m * 5 + c, (c == 3));
            end
        end
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule